// File: doc/BRIEF.md
# Inter-Processor Doorbell Message Unit

This unit lets the processors of a cluster signal one another with short message words. A send command carries a message word whose type field chooses which kind of doorbell to ring, and whose tag field, or broadcast flag, chooses which processors receive it. Each processor owns a small set of pending bits, one per doorbell kind. Its hard-interrupt request line stays high while any of those bits is set. A clear command carries a message word and the index of the issuing processor, and it drops the decoded pending bit on that processor alone.

Each processor's identifier comes from an identifier table input, one tag-wide slot per processor. A parameter picks the flavour at build time. The embedded flavour decodes a normal and a critical doorbell and honours broadcast. The server flavour accepts one message type, which rings the hypervisor doorbell, and always directs the message to matching processors only. Prioritising the raised requests against other interrupt sources is left to the consumer.

Message layout: type in bits [31:27], broadcast flag in bit 26, tag in bits [13:0]. Pending layout per processor p: bits [3p+2:3p] are {hypervisor, critical, normal}. Send and clear arrive on two independent valid/ready channels. Ready is low in reset and high on every cycle afterwards, so the unit never back-pressures. A command counts only on a cycle where valid and ready are both high, and it takes effect at that clock edge.

Top module: `dbmu_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, every pending bit and every interrupt request is 0 and both ready outputs are 0.
- R2: In the embedded flavour an accepted send of type 0 sets the normal bit (bit 0 of the processor's pending group) and type 1 sets the critical bit (bit 1); the hypervisor bit never sets.
- R3: In the embedded flavour, sends and clears of types 2, 3 and 4 (guest kinds) and of types 6 to 31 change no pending bit.
- R4: In the embedded flavour, a send with bit 26 set sets the decoded bit on every processor whatever the tag.
- R5: A send without broadcast sets the decoded bit on exactly those processors whose identifier-table entry equals bits [13:0]; several can match, and if none match nothing changes.
- R6: An accepted clear drops the decoded pending bit only on the processor named by the clear index; other bits and processors keep their values.
- R7: In the server flavour only type 5 is valid and it sets or clears the hypervisor bit (bit 2); every other type makes the command a no-op, and the normal and critical bits never set.
- R8: In the server flavour bit 26 has no effect; a send reaches only processors whose identifier matches the tag.
- R9: A processor's interrupt request is high exactly when any of its pending bits is high, so it rises in the cycle after the send that set a bit.
- R10: When a send and a clear hit the same bit of the same processor in one cycle, the bit ends set.
- R11: Out of reset both ready outputs stay high; a command whose valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| snd_valid | input | 1 | Send command present |
| snd_ready | output | 1 | Send channel can accept |
| snd_msg | input | MSG_W | Send message word |
| clr_valid | input | 1 | Clear command present |
| clr_ready | output | 1 | Clear channel can accept |
| clr_msg | input | MSG_W | Clear message word |
| clr_cpu | input | CPU_W | Index of the processor issuing the clear |
| id_table | input | NPROC*TAG_W | Identifier of each processor, slot p at [p*TAG_W +: TAG_W] |
| pend | output | NPROC*3 | Pending bits, {hyp, crit, normal} per processor |
| irq | output | NPROC | Hard-interrupt request per processor |

## Verification
The assertions take the identifier table to be static while commands flow and the clear index to name an existing processor; a rising or falling pending bit is then always traced to an accepted command in the cycle before. The stimulus holds one fixed table that includes a shared identifier, keeps every clear index below the processor count, and drives both flavours with identical command streams, so that the server instance also sees the broadcast and embedded types that it must ignore.

// File: rtl/dbmu_pkg.sv
package dbmu_pkg;
  // pending kinds, position within a processor's pending group
  localparam int KIND_N    = 3;
  localparam int KIND_NORM = 0;
  localparam int KIND_CRIT = 1;
  localparam int KIND_HYP  = 2;

  // message type field
  localparam int TYPE_W = 5;
  localparam logic [TYPE_W-1:0] TY_NORM = 5'd0;
  localparam logic [TYPE_W-1:0] TY_CRIT = 5'd1;
  localparam logic [TYPE_W-1:0] TY_HYP  = 5'd5;

  function automatic logic [KIND_N-1:0] kind_mask(input int k);
    logic [KIND_N-1:0] m;
    m = '0;
    m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dbmu_kind_dec.sv
module dbmu_kind_dec
  import dbmu_pkg::*;
#(
  parameter bit SERVER = 1'b0
) (
  input  logic [TYPE_W-1:0] ty,
  output logic [KIND_N-1:0] kind_oh
);
  generate
    if (SERVER) begin : g_server
      // directed hypervisor doorbell only
      always_comb begin
        kind_oh = '0;
        if (ty == TY_HYP) kind_oh = kind_mask(KIND_HYP);
      end
    end else begin : g_embedded
      // guest kinds and unknown codes decode to nothing
      always_comb begin
        case (ty)
          TY_NORM: kind_oh = kind_mask(KIND_NORM);
          TY_CRIT: kind_oh = kind_mask(KIND_CRIT);
          default: kind_oh = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/dbmu_target.sv
module dbmu_target #(
  parameter int NPROC = 4,
  parameter int TAG_W = 14
) (
  input  logic                   bcast,
  input  logic [TAG_W-1:0]       tag,
  input  logic [NPROC*TAG_W-1:0] id_table,
  output logic [NPROC-1:0]       hit
);
  for (genvar p = 0; p < NPROC; p++) begin : g_cmp
    assign hit[p] = bcast || (id_table[p*TAG_W +: TAG_W] == tag);
  end
endmodule

// File: rtl/dbmu_pend_bank.sv
module dbmu_pend_bank
  import dbmu_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int CPU_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_en,
  input  logic [NPROC-1:0]        set_hit,
  input  logic [KIND_N-1:0]       set_oh,
  input  logic                    clr_en,
  input  logic [CPU_W-1:0]        clr_cpu,
  input  logic [KIND_N-1:0]       clr_oh,
  output logic [NPROC*KIND_N-1:0] pend,
  output logic [NPROC-1:0]        irq
);
  for (genvar p = 0; p < NPROC; p++) begin : g_cpu
    logic [KIND_N-1:0] q;
    logic [KIND_N-1:0] set_vec;
    logic [KIND_N-1:0] clr_vec;

    assign set_vec = (set_en && set_hit[p]) ? set_oh : '0;
    assign clr_vec = (clr_en && (clr_cpu == CPU_W'(p))) ? clr_oh : '0;

    // clear applied first, so a coincident set survives
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= (q & ~clr_vec) | set_vec;
    end

    assign pend[p*KIND_N +: KIND_N] = q;
    assign irq[p] = |q;
  end
endmodule

// File: rtl/dbmu_top.sv
module dbmu_top
  import dbmu_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int TAG_W  = 14,
  parameter int MSG_W  = 32,
  parameter bit SERVER = 1'b0,
  parameter int CPU_W  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snd_valid,
  output logic                    snd_ready,
  input  logic [MSG_W-1:0]        snd_msg,
  input  logic                    clr_valid,
  output logic                    clr_ready,
  input  logic [MSG_W-1:0]        clr_msg,
  input  logic [CPU_W-1:0]        clr_cpu,
  input  logic [NPROC*TAG_W-1:0]  id_table,
  output logic [NPROC*KIND_N-1:0] pend,
  output logic [NPROC-1:0]        irq
);
  localparam int TYPE_LSB  = MSG_W - TYPE_W;
  localparam int BCAST_BIT = TYPE_LSB - 1;

  logic              rdy_q;
  logic              snd_acc, clr_acc;
  logic [KIND_N-1:0] snd_oh, clr_oh;
  logic              bcast;
  logic [NPROC-1:0]  hit;
  logic              unused_bits;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign snd_ready = rdy_q;
  assign clr_ready = rdy_q;
  assign snd_acc   = snd_valid && rdy_q;
  assign clr_acc   = clr_valid && rdy_q;

  assign bcast = SERVER ? 1'b0 : snd_msg[BCAST_BIT];

  assign unused_bits = &{1'b0, snd_msg[BCAST_BIT:TAG_W], clr_msg[BCAST_BIT:0]};

  dbmu_kind_dec #(.SERVER(SERVER)) u_snd_dec (
    .ty      (snd_msg[TYPE_LSB +: TYPE_W]),
    .kind_oh (snd_oh)
  );

  dbmu_kind_dec #(.SERVER(SERVER)) u_clr_dec (
    .ty      (clr_msg[TYPE_LSB +: TYPE_W]),
    .kind_oh (clr_oh)
  );

  dbmu_target #(.NPROC(NPROC), .TAG_W(TAG_W)) u_target (
    .bcast    (bcast),
    .tag      (snd_msg[TAG_W-1:0]),
    .id_table (id_table),
    .hit      (hit)
  );

  dbmu_pend_bank #(.NPROC(NPROC), .CPU_W(CPU_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_en  (snd_acc),
    .set_hit (hit),
    .set_oh  (snd_oh),
    .clr_en  (clr_acc),
    .clr_cpu (clr_cpu),
    .clr_oh  (clr_oh),
    .pend    (pend),
    .irq     (irq)
  );
endmodule

// File: rtl/dbmu_chk.sv
module dbmu_chk #(
  parameter int NPROC  = 4,
  parameter int CPU_W  = 2,
  parameter int KN     = 3,
  parameter bit SERVER = 1'b0
) (
  input logic                clk,
  input logic                rst,
  input logic                snd_valid,
  input logic                snd_ready,
  input logic                clr_valid,
  input logic                clr_ready,
  input logic [CPU_W-1:0]    clr_cpu,
  input logic [NPROC*KN-1:0] pend,
  input logic [NPROC-1:0]    irq
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend == '0 && irq == '0));

  assert_ready_high_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (snd_ready && clr_ready));

  for (genvar p = 0; p < NPROC; p++) begin : g_p
    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[p]) |-> $past(snd_valid && snd_ready));

    for (genvar k = 0; k < KN; k++) begin : g_k
      assert_set_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[p*KN+k]) |-> $past(snd_valid && snd_ready));

      assert_clear_local_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pend[p*KN+k]) |->
          $past(clr_valid && clr_ready && (clr_cpu == CPU_W'(p))));
    end

    if (SERVER) begin : g_srv
      assert_server_kind_R7: assert property (@(posedge clk) disable iff (rst)
        pend[p*KN +: 2] == 2'b00);
    end else begin : g_emb
      assert_embedded_kind_R2: assert property (@(posedge clk) disable iff (rst)
        pend[p*KN+2] == 1'b0);
    end
  end
endmodule

bind dbmu_top dbmu_chk #(
  .NPROC(NPROC), .CPU_W(CPU_W), .KN(dbmu_pkg::KIND_N), .SERVER(SERVER)
) u_chk (
  .clk(clk), .rst(rst),
  .snd_valid(snd_valid), .snd_ready(snd_ready),
  .clr_valid(clr_valid), .clr_ready(clr_ready),
  .clr_cpu(clr_cpu), .pend(pend), .irq(irq)
);

// File: tb/dbmu_top_tb.sv
module dbmu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int TW = 14;
  localparam int MW = 32;
  localparam int CW = 2;
  localparam logic [TW-1:0] ID0 = 14'h0010, ID1 = 14'h0021,
                            ID2 = 14'h0010, ID3 = 14'h3FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snd_valid = 1'b0, clr_valid = 1'b0;
  logic [MW-1:0] snd_msg = '0, clr_msg = '0;
  logic [CW-1:0] clr_cpu = '0;
  logic [NP*TW-1:0] id_table;
  logic snd_rdy_e, clr_rdy_e, snd_rdy_s, clr_rdy_s;
  logic [NP*3-1:0] pend_e, pend_s;
  logic [NP-1:0] irq_e, irq_s;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R1";

  assign id_table = {ID3, ID2, ID1, ID0};
  always #(CLK_PERIOD/2) clk = ~clk;

  dbmu_top #(.NPROC(NP), .TAG_W(TW), .MSG_W(MW), .SERVER(1'b0)) u_dut (
    .clk(clk), .rst(rst), .snd_valid(snd_valid), .snd_ready(snd_rdy_e),
    .snd_msg(snd_msg), .clr_valid(clr_valid), .clr_ready(clr_rdy_e),
    .clr_msg(clr_msg), .clr_cpu(clr_cpu), .id_table(id_table),
    .pend(pend_e), .irq(irq_e));

  dbmu_top #(.NPROC(NP), .TAG_W(TW), .MSG_W(MW), .SERVER(1'b1)) u_dut_srv (
    .clk(clk), .rst(rst), .snd_valid(snd_valid), .snd_ready(snd_rdy_s),
    .snd_msg(snd_msg), .clr_valid(clr_valid), .clr_ready(clr_rdy_s),
    .clr_msg(clr_msg), .clr_cpu(clr_cpu), .id_table(id_table),
    .pend(pend_s), .irq(irq_s));

  // ---------------- reference model ----------------
  logic [2:0] m_e [NP];
  logic [2:0] m_s [NP];
  logic m_rdy = 1'b0;

  function automatic logic [TW-1:0] id_of(input int p);
    case (p)
      0: return ID0;
      1: return ID1;
      2: return ID2;
      default: return ID3;
    endcase
  endfunction

  function automatic int emb_idx(input logic [4:0] t);
    if (t == 5'd0) return 0;
    if (t == 5'd1) return 1;
    return -1;
  endfunction

  function automatic int srv_idx(input logic [4:0] t);
    return (t == 5'd5) ? 2 : -1;
  endfunction

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      logic [2:0] ne, ns;
      int ke, ks;
      ne = m_e[p];
      ns = m_s[p];
      if (rst) begin
        ne = '0;
        ns = '0;
      end else begin
        if (clr_valid && m_rdy && int'(clr_cpu) == p) begin
          ke = emb_idx(clr_msg[31:27]);
          ks = srv_idx(clr_msg[31:27]);
          if (ke >= 0) ne[ke] = 1'b0;
          if (ks >= 0) ns[ks] = 1'b0;
        end
        if (snd_valid && m_rdy) begin
          ke = emb_idx(snd_msg[31:27]);
          ks = srv_idx(snd_msg[31:27]);
          if (ke >= 0 && (snd_msg[26] || snd_msg[13:0] == id_of(p))) ne[ke] = 1'b1;
          if (ks >= 0 && snd_msg[13:0] == id_of(p)) ns[ks] = 1'b1;
        end
      end
      m_e[p] <= ne;
      m_s[p] <= ns;
    end
    m_rdy <= !rst;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [NP*3-1:0] xe, xs;
      logic [NP-1:0] ie, is;
      for (int p = 0; p < NP; p++) begin
        xe[p*3 +: 3] = m_e[p];
        xs[p*3 +: 3] = m_s[p];
        ie[p] = |m_e[p];
        is[p] = |m_s[p];
      end
      chk(cur_req, "embedded pend/irq/ready",
          {pend_e, irq_e, snd_rdy_e, clr_rdy_e}, {xe, ie, m_rdy, m_rdy});
      chk(cur_req, "server pend/irq/ready",
          {pend_s, irq_s, snd_rdy_s, clr_rdy_s}, {xs, is, m_rdy, m_rdy});
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [MW-1:0] mk(input logic [4:0] t, input logic b,
                                       input logic [TW-1:0] tag);
    return {t, b, 12'h000, tag};
  endfunction

  task automatic drive(input logic sv, input logic [MW-1:0] sm,
                       input logic cv, input logic [MW-1:0] cm,
                       input logic [CW-1:0] cc);
    @(posedge clk);
    #1;
    snd_valid = sv; snd_msg = sm;
    clr_valid = cv; clr_msg = cm; clr_cpu = cc;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    snd_valid = 1'b0;
    clr_valid = 1'b0;
  endtask

  task automatic snd(input logic [4:0] t, input logic b, input logic [TW-1:0] tag);
    drive(1'b1, mk(t, b, tag), 1'b0, '0, '0);
    idle();
  endtask

  task automatic clr(input logic [4:0] t, input logic [CW-1:0] c);
    drive(1'b0, '0, 1'b1, mk(t, 1'b0, '0), c);
    idle();
  endtask

  task automatic look(input string req, input string what,
                      input logic [11:0] ge, input logic [11:0] ee);
    @(negedge clk);
    chk(req, what, {52'b0, ge}, {52'b0, ee});
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready during reset", {62'b0, snd_rdy_e, clr_rdy_e}, 64'd0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "pend after reset", {52'b0, pend_e}, 64'd0);

    cur_req = "R2";
    snd(5'd0, 1'b0, ID1);
    snd(5'd1, 1'b0, ID3);
    look("R2", "normal on cpu1, critical on cpu3", pend_e, 12'b010_000_001_000);
    cur_req = "R9";
    @(negedge clk);
    chk("R9", "irq lines", {60'b0, irq_e}, 64'b1010);

    cur_req = "R6";
    clr(5'd0, 2'd1);
    clr(5'd1, 2'd0);
    look("R6", "clear cpu1 normal only", pend_e, 12'b010_000_000_000);
    clr(5'd1, 2'd3);
    look("R6", "clear cpu3 critical", pend_e, 12'b000);

    cur_req = "R3";
    snd(5'd2, 1'b1, ID0);
    snd(5'd3, 1'b1, ID0);
    snd(5'd4, 1'b1, ID0);
    snd(5'd7, 1'b1, ID0);
    snd(5'd31, 1'b0, ID1);
    look("R3", "guest and unknown types ignored", pend_e, 12'b0);

    cur_req = "R4";
    snd(5'd1, 1'b1, 14'h0555);
    look("R4", "broadcast critical", pend_e, 12'b010_010_010_010);
    clr(5'd3, 2'd0);
    look("R3", "guest-type clear ignored", pend_e, 12'b010_010_010_010);
    for (int c = 0; c < NP; c++) clr(5'd1, CW'(c));

    cur_req = "R5";
    snd(5'd0, 1'b0, 14'h0010);
    look("R5", "shared id hits cpu0 and cpu2", pend_e, 12'b000_001_000_001);
    snd(5'd1, 1'b0, 14'h0999);
    look("R5", "no id match", pend_e, 12'b000_001_000_001);

    cur_req = "R10";
    drive(1'b1, mk(5'd0, 1'b0, ID0), 1'b1, mk(5'd0, 1'b0, '0), 2'd0);
    idle();
    look("R10", "set wins over clear", pend_e, 12'b000_001_000_001);

    cur_req = "R11";
    drive(1'b0, mk(5'd1, 1'b1, '0), 1'b0, mk(5'd0, 1'b0, '0), 2'd2);
    idle();
    look("R11", "invalid commands ignored", pend_e, 12'b000_001_000_001);
    clr(5'd0, 2'd0);
    clr(5'd0, 2'd2);

    cur_req = "R7";
    snd(5'd5, 1'b0, ID1);
    snd(5'd0, 1'b0, ID1);
    snd(5'd1, 1'b0, ID3);
    look("R7", "server hyp bit on cpu1 only", pend_s, 12'b000_000_100_000);
    clr(5'd0, 2'd1);
    look("R7", "server clear of other type is no-op", pend_s, 12'b000_000_100_000);
    clr(5'd5, 2'd1);
    look("R7", "server hyp clear", pend_s, 12'b0);

    cur_req = "R8";
    snd(5'd5, 1'b1, ID0);
    look("R8", "broadcast flag ignored by server", pend_s, 12'b000_100_000_100);
    clr(5'd5, 2'd0);
    clr(5'd5, 2'd2);

    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [4:0] t, tc;
      logic [TW-1:0] tg;
      case ($urandom_range(0, 4))
        0: t = 5'd0; 1: t = 5'd1; 2: t = 5'd5; 3: t = 5'd2; default: t = 5'd31;
      endcase
      case ($urandom_range(0, 2))
        0: tc = 5'd0; 1: tc = 5'd1; default: tc = 5'd5;
      endcase
      tg = ($urandom_range(0, 3) == 0) ? 14'(($urandom)) : id_of($urandom_range(0, 3));
      drive(1'($urandom), mk(t, 1'($urandom), tg),
            1'($urandom), mk(tc, 1'b0, '0), CW'($urandom_range(0, 3)));
    end
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule